// File: doc/BRIEF.md
# Hierarchical Power State Resolver

This block watches the condition inputs of one power-managed domain and of the supply set that powers it. Once per clock it names a single current power state for each of the two objects. Each object has a few fundamental states and some narrower refinements of them. Every state is a predicate over the inputs, so several states can hold in the same cycle. The block resolves that overlap by walking a refinement tree. If no fundamental state holds, the result is UNDEFINED. If two active states do not lie on one branch of the tree, the result is ERROR. Otherwise the deepest active state wins.

The supply set also reports a simulation-behaviour level, which says how conservatively logic on that supply should be treated. An error flag goes high whenever either object resolves to ERROR. A power controller or a monitor uses the outputs to follow the domain's operating mode. All inputs and outputs are plain level signals with no handshake. Each output is a register that follows its inputs one clock later.

Top module: `pss_power_state_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are: `sup_state`=0 (UNDEFINED), `dom_state`=0 (UNDEFINED), `sup_level`=0 (none) and `err_flag`=0.
- R2: Each rail code uses 2'b00 for off, 2'b01 for full-on and 2'b10/2'b11 for undetermined. The supply predicate ON holds when both rails are full-on, and gives `sup_state`=3. The predicate OFF holds when either rail is off, and gives `sup_state`=2 when no other supply state applies.
- R3: When the supply is neither ON nor OFF, `sup_state`=0 (UNDEFINED) and `sup_level`=0.
- R4: The supply refinements of ON are SLOW (ON and `sleep`=1, code 4) and BOOST (ON and `perf_mode[1]`=1, code 5). When exactly one of them holds, it is reported in preference to ON.
- R5: When SLOW and BOOST hold together, `sup_state`=1 (ERROR).
- R6: The `sup_level` codes are 1 NORMAL, 2 corrupt-on-change and 3 CORRUPT. ON and BOOST give 1, SLOW gives 2, OFF and ERROR give 3, and UNDEFINED gives 0. No refinement carries a level below that of its parent.
- R7: The domain state follows the supply predicates. ON gives UP (`dom_state`=4), OFF gives DOWN (code 2), and neither gives UNDEFINED (code 0).
- R8: The domain refinement RET (code 3) holds when the domain is DOWN and `ret_on`=1. `ret_on` has no effect while the supply is ON.
- R9: The domain refinements of UP are IDLE (`sleep`=1, code 5) and TURBO (`perf_mode`=2'b11, code 6). If both hold, `dom_state`=1 (ERROR). `perf_mode` values 2'b01 and 2'b10 leave the domain in UP.
- R10: `err_flag` is 1 in exactly those cycles in which `sup_state` or `dom_state` is ERROR.
- R11: The outputs change only at rising edges. They reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pwr_rail | input | 2 | Power rail status code |
| gnd_rail | input | 2 | Ground rail status code |
| ret_on | input | 1 | Retention supply is on |
| sleep | input | 1 | Sleep control |
| perf_mode | input | 2 | Performance mode |
| sup_state | output | 3 | Current supply set state code |
| dom_state | output | 3 | Current domain state code |
| sup_level | output | 3 | Simulation-behaviour level of the supply set |
| err_flag | output | 1 | Either object is in ERROR |

## Verification
The bench sweeps every combination of the two rail codes, retention, sleep and performance mode. This reaches all the corner cases:
- Mixed rails, one full-on and one undetermined, must give UNDEFINED. A design that treats "not off" as ON reports ON there.
- Sleep together with a high performance mode must give ERROR on both objects. A design that ranks siblings by priority instead reports one of them.
- Retention with the supply up must give UP. A design that tests retention before the parent state reports RET.

The bench also checks that a new input is not visible before the following edge, and that reset in the middle of a run returns both objects to UNDEFINED.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int unsigned RAIL_W = 2;
  localparam logic [RAIL_W-1:0] RAIL_OFF  = 2'b00;
  localparam logic [RAIL_W-1:0] RAIL_FULL = 2'b01;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SUP_UNDEF = 3'd0,
    SUP_ERROR = 3'd1,
    SUP_OFF   = 3'd2,
    SUP_ON    = 3'd3,
    SUP_SLOW  = 3'd4,
    SUP_BOOST = 3'd5
  } sup_code_e;

  typedef enum logic [CODE_W-1:0] {
    DOM_UNDEF = 3'd0,
    DOM_ERROR = 3'd1,
    DOM_DOWN  = 3'd2,
    DOM_RET   = 3'd3,
    DOM_UP    = 3'd4,
    DOM_IDLE  = 3'd5,
    DOM_TURBO = 3'd6
  } dom_code_e;

  typedef enum logic [CODE_W-1:0] {
    LVL_NONE    = 3'd0,
    LVL_NORMAL  = 3'd1,
    LVL_ONCHG   = 3'd2,
    LVL_CORRUPT = 3'd3
  } sim_level_e;

  // Supply-set tree: local index 0 OFF, 1 ON, 2 SLOW, 3 BOOST
  localparam int unsigned SUP_N  = 4;
  localparam int unsigned SUP_IW = 2;
  localparam logic [SUP_N*SUP_IW-1:0] SUP_PARENT = {2'd1, 2'd1, 2'd1, 2'd0};

  // Domain tree: local index 0 DOWN, 1 RET, 2 UP, 3 IDLE, 4 TURBO
  localparam int unsigned DOM_N  = 5;
  localparam int unsigned DOM_IW = 3;
  localparam logic [DOM_N*DOM_IW-1:0] DOM_PARENT = {3'd2, 3'd2, 3'd2, 3'd0, 3'd0};

  // Local index + this offset = external state code
  localparam int unsigned CODE_OFS = 2;

endpackage

// File: rtl/pss_predicates.sv
module pss_predicates
  import pss_pkg::*;
(
  input  logic [RAIL_W-1:0] pwr_rail,
  input  logic [RAIL_W-1:0] gnd_rail,
  input  logic              ret_on,
  input  logic              sleep,
  input  logic [1:0]        perf_mode,
  output logic [SUP_N-1:0]  sup_act,
  output logic [DOM_N-1:0]  dom_act
);

  logic rails_on, rails_off;

  always_comb begin
    rails_on  = (pwr_rail == RAIL_FULL) && (gnd_rail == RAIL_FULL);
    rails_off = (pwr_rail == RAIL_OFF)  || (gnd_rail == RAIL_OFF);

    sup_act[0] = rails_off;
    sup_act[1] = rails_on;
    sup_act[2] = rails_on && sleep;
    sup_act[3] = rails_on && perf_mode[1];

    // Domain predicates refer to supply predicates, not resolved states
    dom_act[0] = sup_act[0];
    dom_act[1] = sup_act[0] && ret_on;
    dom_act[2] = sup_act[1];
    dom_act[3] = sup_act[1] && sleep;
    dom_act[4] = sup_act[1] && (perf_mode == 2'b11);
  end

endmodule

// File: rtl/pss_resolver.sv
module pss_resolver #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1,
  parameter logic [N*IW-1:0] PARENT = '0
) (
  input  logic [N-1:0]  act_i,
  output logic [IW-1:0] sel_o,
  output logic          err_o,
  output logic          undef_o
);

  localparam int unsigned DW = $clog2(N + 1);

  function automatic logic [IW-1:0] parent_of(input int unsigned idx);
    return PARENT[idx*IW +: IW];
  endfunction

  function automatic logic [DW-1:0] depth_of(input int unsigned idx);
    logic [DW-1:0] d;
    int unsigned   k;
    d = '0;
    k = idx;
    for (int s = 0; s < int'(N); s++) begin
      if (int'(parent_of(k)) != int'(k)) begin
        d = d + 1'b1;
        k = int'(parent_of(k));
      end
    end
    return d;
  endfunction

  // True when anc lies on the path from idx up to its root
  function automatic logic on_path(input int unsigned anc, input int unsigned idx);
    int unsigned k;
    logic        hit;
    k   = idx;
    hit = 1'b0;
    for (int s = 0; s <= int'(N); s++) begin
      if (k == anc) hit = 1'b1;
      k = int'(parent_of(k));
    end
    return hit;
  endfunction

  logic [N-1:0] fund_mask;

  generate
    for (genvar g = 0; g < int'(N); g++) begin : g_fund
      assign fund_mask[g] = (int'(PARENT[g*IW +: IW]) == g);
    end
  endgenerate

  always_comb begin
    logic [DW-1:0] best_d;
    logic          found;
    err_o   = 1'b0;
    undef_o = ~|(act_i & fund_mask);
    for (int i = 0; i < int'(N); i++) begin
      for (int j = i + 1; j < int'(N); j++) begin
        if (act_i[i] && act_i[j] &&
            !on_path(i, j) && !on_path(j, i))
          err_o = 1'b1;
      end
    end
    sel_o  = '0;
    best_d = '0;
    found  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (act_i[i] && (!found || depth_of(i) > best_d)) begin
        sel_o  = IW'(i);
        best_d = depth_of(i);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pss_power_state_resolver.sv
module pss_power_state_resolver
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RAIL_W-1:0] pwr_rail,
  input  logic [RAIL_W-1:0] gnd_rail,
  input  logic              ret_on,
  input  logic              sleep,
  input  logic [1:0]        perf_mode,
  output logic [CODE_W-1:0] sup_state,
  output logic [CODE_W-1:0] dom_state,
  output logic [CODE_W-1:0] sup_level,
  output logic              err_flag
);

  logic [SUP_N-1:0]  sup_act;
  logic [DOM_N-1:0]  dom_act;
  logic [SUP_IW-1:0] sup_sel;
  logic [DOM_IW-1:0] dom_sel;
  logic              sup_err, sup_undef, dom_err, dom_undef;

  pss_predicates u_pred (
    .pwr_rail  (pwr_rail),
    .gnd_rail  (gnd_rail),
    .ret_on    (ret_on),
    .sleep     (sleep),
    .perf_mode (perf_mode),
    .sup_act   (sup_act),
    .dom_act   (dom_act)
  );

  pss_resolver #(.N(SUP_N), .IW(SUP_IW), .PARENT(SUP_PARENT)) u_sup_res (
    .act_i   (sup_act),
    .sel_o   (sup_sel),
    .err_o   (sup_err),
    .undef_o (sup_undef)
  );

  pss_resolver #(.N(DOM_N), .IW(DOM_IW), .PARENT(DOM_PARENT)) u_dom_res (
    .act_i   (dom_act),
    .sel_o   (dom_sel),
    .err_o   (dom_err),
    .undef_o (dom_undef)
  );

  logic [CODE_W-1:0] sup_nxt, dom_nxt, lvl_nxt;

  always_comb begin
    if (sup_undef)    sup_nxt = SUP_UNDEF;
    else if (sup_err) sup_nxt = SUP_ERROR;
    else              sup_nxt = CODE_W'(sup_sel) + CODE_W'(CODE_OFS);

    if (dom_undef)    dom_nxt = DOM_UNDEF;
    else if (dom_err) dom_nxt = DOM_ERROR;
    else              dom_nxt = CODE_W'(dom_sel) + CODE_W'(CODE_OFS);

    case (sup_nxt)
      SUP_ON, SUP_BOOST:     lvl_nxt = LVL_NORMAL;
      SUP_SLOW:              lvl_nxt = LVL_ONCHG;
      SUP_OFF, SUP_ERROR:    lvl_nxt = LVL_CORRUPT;
      default:               lvl_nxt = LVL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_state <= SUP_UNDEF;
      dom_state <= DOM_UNDEF;
      sup_level <= LVL_NONE;
      err_flag  <= 1'b0;
    end else begin
      sup_state <= sup_nxt;
      dom_state <= dom_nxt;
      sup_level <= lvl_nxt;
      err_flag  <= (!sup_undef && sup_err) || (!dom_undef && dom_err);
    end
  end

  AST_ERR_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    err_flag == ((sup_state == SUP_ERROR) || (dom_state == DOM_ERROR))); // R10

  AST_ERROR_CORRUPT: assert property (@(posedge clk) disable iff (rst)
    (sup_state == SUP_ERROR) |-> (sup_level == LVL_CORRUPT)); // R5

  AST_UNDEF_NO_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sup_state == SUP_UNDEF) |-> (sup_level == LVL_NONE)); // R3

  AST_REFINE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sup_state == SUP_SLOW || sup_state == SUP_BOOST) |->
      (sup_level >= LVL_NORMAL)); // R6

  AST_DOM_UP_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
    (dom_state >= DOM_UP) |->
      (sup_state == SUP_ON || sup_state == SUP_SLOW ||
       sup_state == SUP_BOOST || sup_state == SUP_ERROR)); // R7

  AST_DOM_DOWN_NEEDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (dom_state == DOM_DOWN || dom_state == DOM_RET) |->
      (sup_state == SUP_OFF)); // R8

  AST_DOM_UNDEF_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (sup_state == SUP_UNDEF) |-> (dom_state == DOM_UNDEF)); // R7

endmodule

// File: tb/tb_pss_power_state_resolver.sv
module tb_pss_power_state_resolver;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] pwr_rail, gnd_rail, perf_mode;
  logic       ret_on, sleep;
  logic [2:0] sup_state, dom_state, sup_level;
  logic       err_flag;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pss_power_state_resolver dut (
    .clk(clk), .rst(rst), .pwr_rail(pwr_rail), .gnd_rail(gnd_rail),
    .ret_on(ret_on), .sleep(sleep), .perf_mode(perf_mode),
    .sup_state(sup_state), .dom_state(dom_state),
    .sup_level(sup_level), .err_flag(err_flag)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int p, input int g, input int r,
                       input int s, input int m);
    pwr_rail  = 2'(p);
    gnd_rail  = 2'(g);
    ret_on    = 1'(r);
    sleep     = 1'(s);
    perf_mode = 2'(m);
  endtask

  function automatic int exp_sup(int p, int g, int s, int m);
    bit on, off, slow, boost;
    on    = (p == 1) && (g == 1);
    off   = (p == 0) || (g == 0);
    slow  = on && (s != 0);
    boost = on && (m >= 2);
    if (!on && !off)     return 0;
    if (slow && boost)   return 1;
    if (slow)            return 4;
    if (boost)           return 5;
    if (on)              return 3;
    return 2;
  endfunction

  function automatic int exp_dom(int p, int g, int r, int s, int m);
    bit up, down, idle, turbo;
    up    = (p == 1) && (g == 1);
    down  = (p == 0) || (g == 0);
    idle  = up && (s != 0);
    turbo = up && (m == 3);
    if (!up && !down)   return 0;
    if (idle && turbo)  return 1;
    if (idle)           return 5;
    if (turbo)          return 6;
    if (up)             return 4;
    if (r != 0)         return 3;
    return 2;
  endfunction

  function automatic int exp_lvl(int sc);
    case (sc)
      3, 5:    return 1;
      4:       return 2;
      1, 2:    return 3;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1, 1, 0, 0, 0);
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "sup_state", int'(sup_state), 0);
    chk("R1", "dom_state", int'(dom_state), 0);
    chk("R1", "sup_level", int'(sup_level), 0);
    chk("R1", "err_flag",  int'(err_flag),  0);
    rst = 1'b0;

    // Exhaustive sweep, R2..R10
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 4; g++)
        for (int r = 0; r < 2; r++)
          for (int s = 0; s < 2; s++)
            for (int m = 0; m < 4; m++) begin
              int es, ed;
              string req_s, req_d;
              drive(p, g, r, s, m);
              @(negedge clk);
              es = exp_sup(p, g, s, m);
              ed = exp_dom(p, g, r, s, m);
              case (es)
                0: req_s = "R3";
                1: req_s = "R5";
                4, 5: req_s = "R4";
                default: req_s = "R2";
              endcase
              case (ed)
                3: req_d = "R8";
                1, 5, 6: req_d = "R9";
                default: req_d = "R7";
              endcase
              chk(req_s, "sup_state", int'(sup_state), es);
              chk(req_d, "dom_state", int'(dom_state), ed);
              chk("R6", "sup_level", int'(sup_level), exp_lvl(es));
              chk("R10", "err_flag", int'(err_flag),
                  ((es == 1) || (ed == 1)) ? 1 : 0);
            end

    // R8: retention ignored while supply is on
    drive(1, 1, 1, 0, 0);
    @(negedge clk);
    chk("R8", "dom_state ret ignored when up", int'(dom_state), 4);

    // R11: output holds until the next rising edge
    drive(0, 1, 0, 0, 0);
    @(negedge clk);
    chk("R11", "sup_state after edge", int'(sup_state), 2);
    drive(1, 1, 0, 0, 0);
    #(CLK_PERIOD/4);
    chk("R11", "sup_state before edge", int'(sup_state), 2);
    @(negedge clk);
    chk("R11", "sup_state next edge", int'(sup_state), 3);

    // R1: reset in the middle of a run
    drive(1, 1, 0, 1, 3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "sup_state mid reset", int'(sup_state), 0);
    chk("R1", "dom_state mid reset", int'(dom_state), 0);
    chk("R1", "err_flag mid reset",  int'(err_flag),  0);
    rst = 1'b0;
    @(negedge clk);
    chk("R5", "sup_state after reset", int'(sup_state), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule